// File: doc/BRIEF.md
# EPP Host-to-Peripheral Cycle Engine

This block sits between a host I/O bus and a parallel port that runs the enhanced (EPP) handshake. The host sees a small window of byte registers: a plain data latch that drives the port lines, a status byte, a control byte, an address-cycle location and a range of data-cycle locations. Host accesses to the address or data-cycle locations become one peripheral cycle each. The block drives the active-low write, data strobe and address strobe lines, and it drives or releases the 8-bit port data lines. It watches the peripheral's wait line to learn when each cycle is done.

While a peripheral cycle is in progress, the block holds the host's ready line low. The host therefore stretches its own strobe until the peripheral raises wait. The block then ends the strobe and reports ready, and the host ends its access. A peripheral that never answers would hang the host. Instead, a clock counter ends the cycle after a set number of clocks and sets a sticky timeout flag in bit 0 of the status byte. Software clears that flag.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, both peripheral strobes and the write line are high, host ready is high, and a status read (offset 1) returns 0x00.
- R2: A host access to offset 3 runs a cycle on the address strobe only. A host access to offsets 4 to 7 runs a cycle on the data strobe only. The two strobes are never low together.
- R3: For an EPP write cycle, the write line is low and the host byte is on the port data lines one clock before the strobe goes low.
- R4: Host ready is low from the clock in which a host EPP access begins until the clock in which the peripheral's wait, sampled high, ends the strobe. For a write, ready is low for one clock more than the clocks the strobe spends low before wait is seen. For a read, ready is low for exactly those clocks.
- R5: The write line never returns high while either strobe is low. It rises only after the strobe has already been high for a clock.
- R6: An EPP read (offset 3 or 4 to 7) returns to the host the port data that was present at the clock edge where the strobe ended.
- R7: If wait stays low for TIMEOUT_CYC clocks of strobe, the cycle ends, ready goes high and status bit 0 becomes 1.
- R8: The timeout flag stays set until the host writes status (offset 1) with bit 0 = 1. A status write with bit 0 = 0 leaves the flag unchanged.
- R9: A write to offset 0 drives that byte on the port data lines outside EPP cycles and reads back. A write to offset 2 reads back unchanged.
- R10: Each host strobe yields at most one peripheral cycle. A new cycle starts only after the host has released its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset within the window |
| host_rd | input | 1 | Host read strobe, held until ready is seen high |
| host_wr | input | 1 | Host write strobe, held until ready is seen high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected offset |
| host_ready | output | 1 | Low while the host access must be stretched |
| pp_data_out | output | 8 | Byte driven toward the peripheral |
| pp_data_oe | output | 1 | High when the block drives the port data lines |
| pp_data_in | input | 8 | Byte present on the port data lines |
| pp_write_n | output | 1 | Active-low write direction line |
| pp_dstrb_n | output | 1 | Active-low data strobe |
| pp_astrb_n | output | 1 | Active-low address strobe |
| pp_wait | input | 1 | Peripheral handshake; high means the cycle can end |

## Verification
The hardest case to reach is the timeout path: the strobe must stay low with wait held low for the full counter window. At the same time the host keeps its strobe asserted, so the status flag is set and the stretched ready is released without help from the peripheral. The bench peripheral model takes a programmable response delay and has a never-respond setting. It runs timeouts on both a write and a read, and counts the exact number of stretched clocks against the window length. The bench then shows that a status write with bit 0 clear keeps the flag and that a write with bit 0 set clears it.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } epp_state_e;

    localparam int OFF_LATCH  = 0;
    localparam int OFF_STATUS = 1;
    localparam int OFF_CTRL   = 2;
    localparam int OFF_ACYC   = 3;

    typedef struct packed {
        epp_state_e state;
        logic       is_epp;
        logic       is_write;
        logic       is_addr;
        logic [7:0] wbyte;
    } seq_s;
endpackage

// File: rtl/epp_timeout_ctr.sv
module epp_timeout_ctr #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && (cnt_q != CW'(LIMIT - 1)))
            cnt_d = cnt_q + 1'b1;
        else if (run)
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // R7: the counter never runs past the window
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < LIMIT);

    // R7: the count restarts whenever a strobe window is not open
    a_r7_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/epp_host_regs.sv
module epp_host_regs
    import epp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              set_timeout,
    input  logic              load_rd,
    input  logic [DW-1:0]     port_byte,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     latch_byte,
    output logic              timeout_flag
);
    typedef struct packed {
        logic [DW-1:0] latch;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] rd;
        logic          tmo;
    } regs_s;

    regs_s r_d, r_q;
    logic  clr_tmo;

    always_comb begin
        r_d     = r_q;
        clr_tmo = wr_en && (32'(addr) == OFF_STATUS) && wdata[0];
        if (wr_en && (32'(addr) == OFF_LATCH)) r_d.latch = wdata;
        if (wr_en && (32'(addr) == OFF_CTRL))  r_d.ctrl  = wdata;
        if (load_rd)                           r_d.rd    = port_byte;
        if (set_timeout)                       r_d.tmo   = 1'b1;
        else if (clr_tmo)                      r_d.tmo   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (32'(addr) >= OFF_ACYC)           rdata = r_q.rd;
        else if (32'(addr) == OFF_CTRL)      rdata = r_q.ctrl;
        else if (32'(addr) == OFF_STATUS)    rdata = {{(DW-1){1'b0}}, r_q.tmo};
        else                                 rdata = r_q.latch;
    end

    assign latch_byte   = r_q.latch;
    assign timeout_flag = r_q.tmo;

    // R8: a set flag survives every cycle without a clearing write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tmo && !(wr_en && (32'(addr) == OFF_STATUS) && wdata[0])) |=> r_q.tmo);
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1250,
    parameter int ADDR_W      = 3,
    parameter int DW          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_ready,
    output logic [DW-1:0]     pp_data_out,
    output logic              pp_data_oe,
    input  logic [DW-1:0]     pp_data_in,
    output logic              pp_write_n,
    output logic              pp_dstrb_n,
    output logic              pp_astrb_n,
    input  logic              pp_wait
);
    seq_s          s_d, s_q;
    logic          start_any, epp_sel, expired;
    logic          reg_wr, set_tmo, load_rd;
    logic [DW-1:0] latch_byte;
    logic          timeout_flag;

    assign start_any = host_rd || host_wr;
    assign epp_sel   = 32'(host_addr) >= OFF_ACYC;

    always_comb begin
        s_d     = s_q;
        reg_wr  = 1'b0;
        set_tmo = 1'b0;
        load_rd = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_any) begin
                    s_d.is_write = host_wr;
                    s_d.is_addr  = 32'(host_addr) == OFF_ACYC;
                    s_d.is_epp   = epp_sel;
                    s_d.wbyte    = host_wdata;
                    if (epp_sel) begin
                        s_d.state = host_wr ? ST_SETUP : ST_STROBE;
                    end else begin
                        reg_wr    = host_wr;
                        s_d.state = ST_DONE;
                    end
                end
            end
            ST_SETUP: s_d.state = ST_STROBE;
            ST_STROBE: begin
                if (pp_wait) begin
                    s_d.state = ST_DONE;
                    load_rd   = !s_q.is_write;
                end else if (expired) begin
                    s_d.state = ST_DONE;
                    set_tmo   = 1'b1;
                    load_rd   = !s_q.is_write;
                end
            end
            ST_DONE: begin
                if (!start_any) begin
                    s_d.state  = ST_IDLE;
                    s_d.is_epp = 1'b0;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, is_epp: 1'b0, is_write: 1'b0,
                             is_addr: 1'b0, wbyte: '0};
        else        s_q <= s_d;
    end

    epp_timeout_ctr #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.state == ST_STROBE),
        .expired (expired)
    );

    epp_host_regs #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (host_addr),
        .wr_en        (reg_wr),
        .wdata        (host_wdata),
        .set_timeout  (set_tmo),
        .load_rd      (load_rd),
        .port_byte    (pp_data_in),
        .rdata        (host_rdata),
        .latch_byte   (latch_byte),
        .timeout_flag (timeout_flag)
    );

    logic epp_busy, epp_wr_active;
    assign epp_busy      = s_q.is_epp && (s_q.state != ST_IDLE);
    assign epp_wr_active = epp_busy && s_q.is_write;

    assign pp_write_n  = !epp_wr_active;
    assign pp_dstrb_n  = !((s_q.state == ST_STROBE) && !s_q.is_addr);
    assign pp_astrb_n  = !((s_q.state == ST_STROBE) &&  s_q.is_addr);
    assign pp_data_out = epp_wr_active ? s_q.wbyte : latch_byte;
    assign pp_data_oe  = !(epp_busy && !s_q.is_write);
    assign host_ready  = !(((s_q.state == ST_IDLE) && start_any && epp_sel) ||
                           (s_q.state == ST_SETUP) || (s_q.state == ST_STROBE));

    // R2: never both strobes low
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pp_dstrb_n && !pp_astrb_n));

    // R3: a write strobe is preceded by a clock with write already low
    a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(pp_dstrb_n) || $fell(pp_astrb_n)) && !pp_write_n) |-> !$past(pp_write_n));

    // R4: ready stays low while any strobe is low
    a_r4_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!pp_dstrb_n || !pp_astrb_n) |-> !host_ready);

    // R5: write only rises after the strobes were already high
    a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pp_write_n) |-> ($past(pp_dstrb_n) && $past(pp_astrb_n)));

    // R7: an expired window with wait low ends the strobe and sets the flag
    a_r7_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !pp_wait) |=> (pp_dstrb_n && pp_astrb_n && host_ready && timeout_flag));
endmodule

// File: tb/epp_cycle_engine_test.sv
module epp_cycle_engine_test;
    localparam int TO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic [7:0] pp_data_out;
    logic       pp_data_oe;
    logic [7:0] pp_data_in = '0;
    logic       pp_write_n, pp_dstrb_n, pp_astrb_n;
    logic       pp_wait = 1'b0;

    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    epp_cycle_engine #(.TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .pp_data_out(pp_data_out), .pp_data_oe(pp_data_oe),
        .pp_data_in(pp_data_in), .pp_write_n(pp_write_n), .pp_dstrb_n(pp_dstrb_n),
        .pp_astrb_n(pp_astrb_n), .pp_wait(pp_wait));

    // peripheral model
    int   wait_delay = 1;
    bit   never = 1'b0;
    int   low_cnt = 0;
    bit   was_low = 1'b0;
    logic prev_wn = 1'b1;
    logic [7:0] prev_data = '0;
    int   strobe_falls = 0;
    bit   last_was_addr = 1'b0;
    logic setup_wn = 1'b1;
    logic [7:0] setup_data = '0;
    int   bad_write_rise = 0;
    logic prev_strobes_high = 1'b1;

    always @(negedge clk) begin
        logic lo;
        lo = !pp_dstrb_n || !pp_astrb_n;
        if (lo) begin
            if (!was_low) begin
                strobe_falls++;
                last_was_addr = !pp_astrb_n;
                setup_wn = prev_wn;
                setup_data = prev_data;
            end
            low_cnt++;
            if (!never && low_cnt >= wait_delay) pp_wait = 1'b1;
        end else begin
            low_cnt = 0;
            pp_wait = 1'b0;
        end
        if (pp_write_n && !prev_wn && !prev_strobes_high) bad_write_rise++;
        was_low = lo;
        prev_wn = pp_write_n;
        prev_data = pp_data_out;
        prev_strobes_high = !lo;
    end

    // scoreboard
    typedef struct { string req; logic [7:0] val; } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                item_t a, e;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                checks++;
                if (a.val !== e.val) begin
                    failures++;
                    $display("FAIL %s read: actual %02h expected %02h", e.req, a.val, e.val);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int stretch = 0;

    task automatic access(input bit wr, input logic [2:0] a, input logic [7:0] d,
                          input int hold, output logic [7:0] rd);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = wr; host_rd = !wr;
        stretch = 0;
        @(negedge clk);
        while (!host_ready && stretch < 5000) begin
            stretch++;
            @(negedge clk);
        end
        rd = host_rdata;
        repeat (hold) @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        item_t e, r;
        e.req = req; e.val = exp;
        exp_q.push_back(e);
        access(1'b0, a, 8'h00, 0, v);
        r.req = req; r.val = v;
        act_q.push_back(r);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input int hold);
        logic [7:0] v;
        access(1'b1, a, d, hold, v);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dstrb", pp_dstrb_n, 1);
        check("R1 astrb", pp_astrb_n, 1);
        check("R1 write", pp_write_n, 1);
        check("R1 ready", host_ready, 1);
        host_read(3'd1, 8'h00, "R1 status");

        // R9 latch and control
        host_write(3'd0, 8'hA5, 0);
        check("R9 latch drive", pp_data_out, 8'hA5);
        check("R9 latch oe", pp_data_oe, 1);
        host_read(3'd0, 8'hA5, "R9 latch");
        host_write(3'd2, 8'h3C, 0);
        host_read(3'd2, 8'h3C, "R9 ctrl");
        check("R9 no strobe", strobe_falls, 0);

        // EPP data write, delay 2
        wait_delay = 2;
        f0 = strobe_falls;
        host_write(3'd4, 8'h96, 0);
        check("R2 data strobe", last_was_addr, 0);
        check("R3 setup write", setup_wn, 0);
        check("R3 setup data", setup_data, 8'h96);
        check("R4 write stretch", stretch, 3);
        check("R5 write rise", bad_write_rise, 0);
        check("R2 one cycle", strobe_falls - f0, 1);
        check("R9 latch restored", pp_data_out, 8'hA5);

        // EPP address write, delay 3
        wait_delay = 3;
        host_write(3'd3, 8'h21, 0);
        check("R2 addr strobe", last_was_addr, 1);
        check("R3 addr setup data", setup_data, 8'h21);
        check("R4 addr stretch", stretch, 4);

        // EPP data read, delay 1
        wait_delay = 1;
        pp_data_in = 8'h5C;
        host_read(3'd6, 8'h5C, "R6 data read");
        check("R4 read stretch", stretch, 1);
        check("R2 read data strobe", last_was_addr, 0);

        // EPP address read, delay 4
        wait_delay = 4;
        pp_data_in = 8'h81;
        host_read(3'd3, 8'h81, "R6 addr read");
        check("R4 addr read stretch", stretch, 4);
        check("R2 read addr strobe", last_was_addr, 1);

        // R10 host holds strobe after ready
        wait_delay = 1;
        f0 = strobe_falls;
        host_write(3'd5, 8'h11, 6);
        check("R10 single cycle", strobe_falls - f0, 1);
        check("R5 after hold", bad_write_rise, 0);

        // R7 timeout on write
        never = 1'b1;
        host_write(3'd4, 8'h77, 0);
        check("R7 write window", stretch, TO + 1);
        check("R7 strobes high", pp_dstrb_n && pp_astrb_n, 1);
        host_read(3'd1, 8'h01, "R7 flag set");

        // R8 sticky flag
        host_write(3'd1, 8'h00, 0);
        host_read(3'd1, 8'h01, "R8 keep on zero");
        host_write(3'd1, 8'h01, 0);
        host_read(3'd1, 8'h00, "R8 clear on one");

        // R7 timeout on read
        host_read(3'd7, 8'h81, "R7 read value at strobe end");
        check("R7 read window", stretch, TO);
        host_read(3'd1, 8'h01, "R7 read flag");
        never = 1'b0;

        wait (act_q.size() == 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule